// File: doc/BRIEF.md
# Cumulative Running Mean Estimator

This block estimates the DC level of a signed sample stream. Its estimate is the arithmetic mean of every sample accepted since the last clear. Each incoming sample is added into a wide signed sum, and a sample counter is incremented. Every accepted sample then starts a division of the sum by the count, and that division produces a fresh mean. Both sum and count are exact, so the estimate never drifts the way a recursive `(n-1)/n` weighted update can.

The divider is a sequential restoring divider that produces one quotient bit per clock. It divides the magnitude of the sum and then applies the sign of the sum, so the quotient truncates toward zero. The ready output is low while a division is pending or running, which holds off the next sample. A synchronous clear empties the sum and the count and aborts any division in progress.

Top module: `rm_mean_est`

## Requirements
- R1: After reset, `in_ready_o` is 1, `mean_valid_o` is 0 and `mean_o` is 0.
- R2: The first result after a clear equals the first accepted sample.
- R3: The second result equals the sum of the first two samples divided by two.
- R4: After n accepted samples, `mean_o` equals the exact sum of those n samples divided by n, with no accumulated error over long runs.
- R5: Division truncates toward zero. For example, samples -3 and -2 give -2, and samples 3 and 2 give 2.
- R6: `in_ready_o` is 0 from the cycle after an accepting edge until the result is presented. A sample offered while `in_ready_o` is 0 is not accepted and does not affect later means.
- R7: `mean_valid_o` is a one-cycle pulse that rises exactly SUM_W+1 clock edges after the accepting edge. `in_ready_o` returns to 1 in the same cycle.
- R8: `clear_i` zeroes the sum and the count, aborts any running division (no result pulse follows), and drops `mean_valid_o`. It takes priority over a sample offered in the same cycle, and `in_ready_o` is 1 in the cycle after it.
- R9: The count saturates at 2^CNT_W-1. A sample accepted at that count leaves the sum and the count unchanged, and the division still runs and repeats the previous mean.
- R10: Full-scale samples (-32768 and 32767 for a 16-bit sample) give exact means, with no overflow in the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of sum, count and division |
| sample_i | input | SAMPLE_W | Signed input sample |
| sample_valid_i | input | 1 | Sample offered |
| in_ready_o | output | 1 | Block can accept a sample this cycle |
| mean_o | output | SAMPLE_W | Signed mean, truncated toward zero |
| mean_valid_o | output | 1 | One-cycle pulse when `mean_o` is new |

## Verification
After the edge that accepts a sample, one register edge launches the division and SUM_W edges shift out the quotient bits. The result pulse therefore appears SUM_W+1 edges after acceptance. The bench counts edges from the accepting edge and samples at the following falling edge. It checks that the pulse appears on exactly that count and carries the value computed by a reference sum/count model, and that the pulse is gone one cycle later. Checks of ignored samples and clears are made only after the next full result, so that any stray effect on the sum would show in `mean_o`.

// File: rtl/rm_pkg.sv
package rm_pkg;
  typedef enum logic [0:0] {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/rm_accum.sv
module rm_accum #(
  parameter int SAMPLE_W = 16,
  parameter int SUM_W    = 40,
  parameter int CNT_W    = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    acc_en_i,
  input  logic [SAMPLE_W-1:0]     sample_i,
  output logic signed [SUM_W-1:0] sum_o,
  output logic [CNT_W-1:0]        cnt_o,
  output logic                    full_o
);
  localparam int EXT_W = SUM_W - SAMPLE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic signed [SUM_W-1:0] sample_ext;
  assign sample_ext = {{EXT_W{sample_i[SAMPLE_W-1]}}, sample_i};
  assign full_o     = (cnt_o == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o <= '0;
      cnt_o <= '0;
    end else if (clear_i) begin
      sum_o <= '0;
      cnt_o <= '0;
    end else if (acc_en_i && !full_o) begin
      sum_o <= sum_o + sample_ext;
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  // saturated count stays put until clear
  p_cnt_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !clear_i |=> full_o);
endmodule

// File: rtl/rm_divider.sv
module rm_divider #(
  parameter int SUM_W = 40,
  parameter int CNT_W = 24,
  parameter int OUT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    abort_i,
  input  logic                    start_i,
  input  logic signed [SUM_W-1:0] sum_i,
  input  logic [CNT_W-1:0]        cnt_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [OUT_W-1:0]        quot_o
);
  import rm_pkg::*;

  localparam int STEP_W = $clog2(SUM_W + 1);

  div_state_e         state_q;
  logic               neg_q;
  logic [SUM_W-1:0]   dvd_q;
  logic [CNT_W-1:0]   rem_q;
  logic [CNT_W-1:0]   div_q;
  logic [STEP_W-1:0]  step_q;

  logic [SUM_W-1:0]   mag;
  logic [CNT_W:0]     rem_sh;
  logic [CNT_W-1:0]   rem_diff;
  logic               fits;
  logic [SUM_W-1:0]   dvd_nx;
  logic [CNT_W-1:0]   rem_nx;
  logic [OUT_W-1:0]   mag_lo;
  logic [OUT_W-1:0]   quot_nx;

  assign mag      = sum_i[SUM_W-1] ? -sum_i : sum_i;
  assign rem_sh   = {rem_q, dvd_q[SUM_W-1]};
  assign fits     = (rem_sh >= {1'b0, div_q});
  // remainder stays below divisor, so CNT_W bits of the difference suffice
  assign rem_diff = rem_sh[CNT_W-1:0] - div_q;
  assign rem_nx   = fits ? rem_diff : rem_sh[CNT_W-1:0];
  assign dvd_nx   = {dvd_q[SUM_W-2:0], fits};
  assign mag_lo   = dvd_nx[OUT_W-1:0];
  assign quot_nx  = neg_q ? -mag_lo : mag_lo;
  assign busy_o   = (state_q == DIV_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DIV_IDLE;
      neg_q   <= 1'b0;
      dvd_q   <= '0;
      rem_q   <= '0;
      div_q   <= '0;
      step_q  <= '0;
      done_o  <= 1'b0;
      quot_o  <= '0;
    end else if (abort_i) begin
      state_q <= DIV_IDLE;
      step_q  <= '0;
      done_o  <= 1'b0;
      quot_o  <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        DIV_IDLE: if (start_i) begin
          state_q <= DIV_RUN;
          neg_q   <= sum_i[SUM_W-1];
          dvd_q   <= mag;
          rem_q   <= '0;
          div_q   <= cnt_i;
          step_q  <= STEP_W'(SUM_W);
        end
        DIV_RUN: begin
          dvd_q  <= dvd_nx;
          rem_q  <= rem_nx;
          step_q <= step_q - STEP_W'(1);
          if (step_q == STEP_W'(1)) begin
            state_q <= DIV_IDLE;
            done_o  <= 1'b1;
            quot_o  <= quot_nx;
          end
        end
        default: state_q <= DIV_IDLE;
      endcase
    end
  end

  p_start_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  p_div_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (cnt_i != '0));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_abort_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !busy_o && !done_o);
endmodule

// File: rtl/rm_mean_est.sv
module rm_mean_est #(
  parameter int SAMPLE_W = 16,
  parameter int SUM_W    = 40,
  parameter int CNT_W    = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_valid_i,
  output logic                in_ready_o,
  output logic [SAMPLE_W-1:0] mean_o,
  output logic                mean_valid_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic                    accept;
  logic                    start_q;
  logic                    busy;
  logic                    full;
  logic signed [SUM_W-1:0] sum;
  logic [CNT_W-1:0]        cnt;

  assign accept     = sample_valid_i && in_ready_o && !clear_i;
  assign in_ready_o = !busy && !start_q;

  rm_accum #(
    .SAMPLE_W (SAMPLE_W),
    .SUM_W    (SUM_W),
    .CNT_W    (CNT_W)
  ) u_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .acc_en_i (accept),
    .sample_i (sample_i),
    .sum_o    (sum),
    .cnt_o    (cnt),
    .full_o   (full)
  );

  // launch one cycle later so the divider sees the updated sum and count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      start_q <= 1'b0;
    else if (clear_i) start_q <= 1'b0;
    else              start_q <= accept;
  end

  rm_divider #(
    .SUM_W (SUM_W),
    .CNT_W (CNT_W),
    .OUT_W (SAMPLE_W)
  ) u_divider (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (clear_i),
    .start_i (start_q),
    .sum_i   (sum),
    .cnt_i   (cnt),
    .busy_o  (busy),
    .done_o  (mean_valid_o),
    .quot_o  (mean_o)
  );

  p_busy_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o && !clear_i |=> $stable(cnt) && $stable(sum));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt == '0) && (sum == '0) && !mean_valid_o && in_ready_o);
  p_valid_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mean_valid_o |-> in_ready_o);
  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !full |=> cnt == $past(cnt) + CNT_W'(1));
  p_sat_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_MAX) && !clear_i |=> $stable(sum));
endmodule

// File: tb/rm_mean_est_bench.sv
module rm_mean_est_bench;
  localparam int SAMPLE_W = 16;
  localparam int CNT_W    = 4;
  localparam int SUM_W    = SAMPLE_W + CNT_W;
  localparam int LAT      = SUM_W + 1;
  localparam int CNT_MAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic signed [SAMPLE_W-1:0] sample = '0;
  logic valid = 1'b0;
  logic in_ready;
  logic signed [SAMPLE_W-1:0] mean;
  logic mean_valid;

  int checks = 0;
  int fails  = 0;
  longint m_sum = 0;
  longint m_n   = 0;
  longint m_mean = 0;

  always #10 clk = ~clk;

  rm_mean_est #(
    .SAMPLE_W (SAMPLE_W),
    .SUM_W    (SUM_W),
    .CNT_W    (CNT_W)
  ) u_rm_mean_est (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .clear_i        (clear),
    .sample_i       (sample),
    .sample_valid_i (valid),
    .in_ready_o     (in_ready),
    .mean_o         (mean),
    .mean_valid_o   (mean_valid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  // offer one sample, optionally spam a junk sample while busy, wait for result
  task automatic push(input logic signed [SAMPLE_W-1:0] s, input bit junk, input string req);
    int e;
    @(negedge clk);
    check(in_ready == 1'b1, req, in_ready, 1);
    sample = s;
    valid  = 1'b1;
    @(posedge clk);
    if (m_n < CNT_MAX) begin
      m_sum += longint'(s);
      m_n++;
    end
    m_mean = m_sum / m_n;
    @(negedge clk);
    valid = 1'b0;
    if (junk) begin
      check(in_ready == 1'b0, "R6 ready low", in_ready, 0);
      sample = 16'sh7fff;
      valid  = 1'b1;
    end
    e = 0;
    do begin
      @(posedge clk);
      e++;
      @(negedge clk);
      if (e == 3) valid = 1'b0;
    end while (!mean_valid && e < 200);
    valid = 1'b0;
    check(e == LAT, "R7 latency", e, LAT);
    check(in_ready == 1'b1, "R7 ready back", in_ready, 1);
    check(longint'(mean) == m_mean, req, mean, m_mean);
    @(negedge clk);
    check(mean_valid == 1'b0, "R7 one-cycle pulse", mean_valid, 0);
  endtask

  task automatic do_clear(input bit with_sample);
    @(negedge clk);
    clear = 1'b1;
    if (with_sample) begin
      sample = 16'sh1234;
      valid  = 1'b1;
    end
    @(negedge clk);
    clear = 1'b0;
    valid = 1'b0;
    m_sum = 0;
    m_n   = 0;
    check(in_ready == 1'b1, "R8 ready after clear", in_ready, 1);
    check(mean_valid == 1'b0, "R8 valid dropped", mean_valid, 0);
  endtask

  task automatic t_reset();
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);
    check(mean_valid == 1'b0, "R1 valid", mean_valid, 0);
    check(mean == '0, "R1 mean", mean, 0);
  endtask

  task automatic t_first_second();
    do_clear(1'b0);
    push(-16'sd1234, 1'b0, "R2 first sample");
    push(16'sd101, 1'b0, "R3 half of two");
  endtask

  task automatic t_trunc();
    do_clear(1'b0);
    push(-16'sd3, 1'b0, "R5 first");
    push(-16'sd2, 1'b0, "R5 negative truncation");
    do_clear(1'b0);
    push(16'sd3, 1'b0, "R5 first pos");
    push(16'sd2, 1'b0, "R5 positive truncation");
  endtask

  task automatic t_long();
    do_clear(1'b0);
    for (int i = 0; i < 12; i++)
      push(SAMPLE_W'((i * 7919) % 4001 - 2000), 1'b0, "R4 exact mean");
  endtask

  task automatic t_busy_ignore();
    do_clear(1'b0);
    push(16'sd500, 1'b1, "R6 first");
    push(-16'sd100, 1'b1, "R6 junk ignored");
  endtask

  task automatic t_abort();
    int seen;
    do_clear(1'b0);
    @(negedge clk);
    sample = 16'sd1000;
    valid  = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    repeat (4) @(negedge clk);
    do_clear(1'b0);
    seen = 0;
    repeat (LAT + 5) begin
      @(negedge clk);
      if (mean_valid) seen++;
    end
    check(seen == 0, "R8 division aborted", seen, 0);
    push(16'sd77, 1'b0, "R8 sum reset");
    do_clear(1'b1);
    push(16'sd10, 1'b0, "R8 clear beats sample");
  endtask

  task automatic t_saturate();
    do_clear(1'b0);
    for (int i = 0; i < CNT_MAX; i++)
      push(SAMPLE_W'(i * 3 - 5), 1'b0, "R9 fill");
    push(16'sd30000, 1'b0, "R9 saturated repeat");
    push(-16'sd30000, 1'b0, "R9 saturated repeat 2");
  endtask

  task automatic t_full_scale();
    do_clear(1'b0);
    for (int i = 0; i < CNT_MAX; i++)
      push(-16'sd32768, 1'b0, "R10 negative full scale");
    do_clear(1'b0);
    for (int i = 0; i < 5; i++)
      push(16'sd32767, 1'b0, "R10 positive full scale");
    push(-16'sd32768, 1'b0, "R10 mixed full scale");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_second();
    t_trunc();
    t_long();
    t_busy_ignore();
    t_abort();
    t_saturate();
    t_full_scale();
    summary();
  end
endmodule